// File: doc/BRIEF.md
# Base Address Window Decoder

This block works out, for a function's base address registers and its expansion-ROM register, which address windows are live and where each one starts. It takes the two space-enable bits of the command register, the value software has programmed into every region register, the power-of-two size of each region and, for the ordinary regions, whether the region claims I/O space or memory space. From these it produces a registered valid flag and an aligned base address for every region. Degenerate windows are refused: a zero base, a window whose end does not lie above its start, an I/O window running past the 64K port space, or a memory window ending at the very top of the address space.

Alongside the window state, the block decodes an incoming transaction. Given an address, a space type and a qualifier, it reports one cycle later whether any live window claims the address, and which one. When windows overlap, the region with the lowest index is chosen. The expansion-ROM region is the last index and always lives in memory space.

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, every valid flag is 0, every base reads all ones and the hit output is 0.
- R2: A region typed as I/O (its bit in `cfg_is_io` set to 1) is valid only while `io_space_en` is 1.
- R3: A memory region, and the ROM region (index NUM_BARS) in all cases, is valid only while `mem_space_en` is 1.
- R4: The ROM region is valid only while bit 0 of its programmed value is 1.
- R5: The base of a valid region is its programmed value AND NOT (size - 1); an invalid region shows a base of all ones. Both appear at the first rising edge after the inputs change.
- R6: A region whose aligned base is zero, or whose last address (base + size - 1, modulo 2^32) is not greater than its base, is invalid.
- R7: An I/O region whose last address is 0x10000 or higher is invalid.
- R8: A memory region whose last address is 0xFFFFFFFF is invalid.
- R9: A region of size zero is never valid.
- R10: A transaction hits a region when `txn_valid` is 1, the region is valid, `txn_is_io` matches the region's space (1 = I/O) and base <= address <= last address; `hit` and `hit_region` are registered and appear at the first rising edge after the transaction is presented, with `hit_region` 0 when there is no hit.
- R11: When a transaction falls in more than one valid region, `hit_region` gives the lowest region index.
- R12: With `txn_valid` at 0 the next `hit` is 0 whatever the address and space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_space_en | input | 1 | Command register I/O-space enable |
| mem_space_en | input | 1 | Command register memory-space enable |
| cfg_value | input | (NUM_BARS+1)*32 | Programmed register value per region, region r at bits r*32 upward, ROM last |
| cfg_size | input | (NUM_BARS+1)*32 | Power-of-two region size per region, 0 = region absent |
| cfg_is_io | input | NUM_BARS | Space type of each ordinary region, 1 = I/O |
| txn_valid | input | 1 | Transaction qualifier |
| txn_addr | input | 32 | Transaction address |
| txn_is_io | input | 1 | Transaction space, 1 = I/O |
| win_valid | output | NUM_BARS+1 | Per-region mapped flag |
| win_base | output | (NUM_BARS+1)*32 | Per-region aligned base, all ones when unmapped |
| hit | output | 1 | Transaction claimed by a live window |
| hit_region | output | $clog2(NUM_BARS+1) | Index of the claiming region |

## Verification
Window state is due at the first rising edge after the configuration or command bits change, so the bench changes configuration on a falling edge and compares every region's flag and base two nanoseconds after the following rising edge. A hit result is due one edge after the transaction, and it is computed from the window registers, so transactions are issued only after the window check for the current configuration has passed. The driver queues the expected hit and index at the moment it presents a transaction, and the monitor pops exactly one entry after each rising edge that follows, keeping each expected value aligned to its own cycle.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    parameter int ADDR_W = 32;

    localparam logic [ADDR_W-1:0] ALL_ONES = '1;
    localparam logic [ADDR_W-1:0] IO_LIMIT = ADDR_W'(32'h0001_0000);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    typedef struct packed {
        logic   valid;
        space_e space;
        addr_t  base;
        addr_t  last;
    } window_t;

    function automatic addr_t align_base(addr_t value, addr_t size);
        return value & ~(size - addr_t'(1));
    endfunction

    function automatic logic extent_ok(space_e sp, addr_t base, addr_t last);
        logic ok;
        ok = 1'b1;
        if (base == '0)                           ok = 1'b0;
        if (last <= base)                         ok = 1'b0;
        if (sp == SPACE_IO  && last >= IO_LIMIT)  ok = 1'b0;
        if (sp == SPACE_MEM && last == ALL_ONES)  ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/bar_region_eval.sv
module bar_region_eval
    import bar_dec_pkg::*;
#(
    parameter bit IS_ROM = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    io_en,
    input  logic    mem_en,
    input  addr_t   value,
    input  addr_t   size,
    input  logic    type_io,
    output window_t win_q
);

    space_e space;
    addr_t  base_c;
    addr_t  last_c;
    logic   space_on;
    logic   rom_on;
    logic   ok;

    always_comb begin
        space    = (!IS_ROM && type_io) ? SPACE_IO : SPACE_MEM;
        base_c   = align_base(value, size);
        last_c   = base_c + size - addr_t'(1);
        space_on = (space == SPACE_IO) ? io_en : mem_en;
        rom_on   = IS_ROM ? value[0] : 1'b1;
        ok       = (size != '0) && space_on && rom_on && extent_ok(space, base_c, last_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '{valid: 1'b0, space: SPACE_MEM, base: ALL_ONES, last: ALL_ONES};
        end else begin
            win_q.valid <= ok;
            win_q.space <= space;
            win_q.base  <= ok ? base_c : ALL_ONES;
            win_q.last  <= ok ? last_c : ALL_ONES;
        end
    end

    AST_SIZE_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
        (size == '0) |=> !win_q.valid); // R9

    AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
        ((IS_ROM || !type_io) && !mem_en) |=> !win_q.valid); // R3

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        win_q.valid |-> ((win_q.base & (win_q.last - win_q.base)) == '0)); // R5

    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (rst)
        !win_q.valid |-> (win_q.base == ALL_ONES)); // R5

    AST_NO_DEGENERATE: assert property (@(posedge clk) disable iff (rst)
        win_q.valid |-> (win_q.base != '0 && win_q.last > win_q.base)); // R6

    AST_IO_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (win_q.valid && win_q.space == SPACE_IO) |-> (win_q.last < IO_LIMIT)); // R7

    generate
        if (IS_ROM) begin : g_rom_chk
            AST_ROM_BIT: assert property (@(posedge clk) disable iff (rst)
                !value[0] |=> !win_q.valid); // R4
        end else begin : g_bar_chk
            AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
                (type_io && !io_en) |=> !win_q.valid); // R2
        end
    endgenerate

endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select
    import bar_dec_pkg::*;
#(
    parameter int NREG  = 7,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  window_t          wins [NREG],
    input  logic             txn_valid,
    input  addr_t            txn_addr,
    input  space_e           txn_space,
    output logic             hit_q,
    output logic [IDX_W-1:0] hit_idx_q
);

    logic             any_c;
    logic [IDX_W-1:0] sel_c;

    always_comb begin
        any_c = 1'b0;
        sel_c = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (txn_valid && wins[i].valid && wins[i].space == txn_space &&
                txn_addr >= wins[i].base && txn_addr <= wins[i].last) begin
                any_c = 1'b1;
                sel_c = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q     <= 1'b0;
            hit_idx_q <= '0;
        end else begin
            hit_q     <= any_c;
            hit_idx_q <= sel_c;
        end
    end

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |=> !hit_q); // R12

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> ({1'b0, hit_idx_q} < (IDX_W+1)'(NREG))); // R11

    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit_q |-> (hit_idx_q == '0)); // R10

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int NUM_BARS = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                io_space_en,
    input  logic                                mem_space_en,
    input  logic [(NUM_BARS+1)*ADDR_W-1:0]      cfg_value,
    input  logic [(NUM_BARS+1)*ADDR_W-1:0]      cfg_size,
    input  logic [NUM_BARS-1:0]                 cfg_is_io,
    input  logic                                txn_valid,
    input  logic [ADDR_W-1:0]                   txn_addr,
    input  logic                                txn_is_io,
    output logic [NUM_BARS:0]                   win_valid,
    output logic [(NUM_BARS+1)*ADDR_W-1:0]      win_base,
    output logic                                hit,
    output logic [$clog2(NUM_BARS+1)-1:0]       hit_region
);

    localparam int NREG  = NUM_BARS + 1;
    localparam int IDX_W = $clog2(NREG);

    window_t wins [NREG];

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_region
            if (r < NUM_BARS) begin : g_bar
                bar_region_eval #(.IS_ROM(1'b0)) i_eval (
                    .clk     (clk),
                    .rst     (rst),
                    .io_en   (io_space_en),
                    .mem_en  (mem_space_en),
                    .value   (cfg_value[r*ADDR_W +: ADDR_W]),
                    .size    (cfg_size[r*ADDR_W +: ADDR_W]),
                    .type_io (cfg_is_io[r]),
                    .win_q   (wins[r])
                );
            end else begin : g_rom
                bar_region_eval #(.IS_ROM(1'b1)) i_eval (
                    .clk     (clk),
                    .rst     (rst),
                    .io_en   (io_space_en),
                    .mem_en  (mem_space_en),
                    .value   (cfg_value[r*ADDR_W +: ADDR_W]),
                    .size    (cfg_size[r*ADDR_W +: ADDR_W]),
                    .type_io (1'b0),
                    .win_q   (wins[r])
                );
            end
            assign win_valid[r]                 = wins[r].valid;
            assign win_base[r*ADDR_W +: ADDR_W] = wins[r].base;
        end
    endgenerate

    bar_hit_select #(.NREG(NREG), .IDX_W(IDX_W)) i_hit (
        .clk       (clk),
        .rst       (rst),
        .wins      (wins),
        .txn_valid (txn_valid),
        .txn_addr  (txn_addr),
        .txn_space (space_e'(txn_is_io)),
        .hit_q     (hit),
        .hit_idx_q (hit_region)
    );

endmodule

// File: tb/test_bar_window_decoder.sv
module test_bar_window_decoder;

    localparam int NB    = 6;
    localparam int NR    = NB + 1;
    localparam int IDX_W = $clog2(NR);

    typedef struct {
        logic             hit;
        logic [IDX_W-1:0] idx;
        string            tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic io_en = 1'b0, mem_en = 1'b0;
    logic [31:0] cv [NR];
    logic [31:0] cs [NR];
    logic        cio [NB];
    logic [NR*32-1:0] cfg_value, cfg_size;
    logic [NB-1:0]    cfg_is_io;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        txn_is_io = 1'b0;
    logic [NR-1:0]    win_valid;
    logic [NR*32-1:0] win_base;
    logic             hit;
    logic [IDX_W-1:0] hit_region;

    int checks = 0;
    int failures = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    always_comb begin
        for (int r = 0; r < NR; r++) begin
            cfg_value[r*32 +: 32] = cv[r];
            cfg_size[r*32 +: 32]  = cs[r];
        end
        for (int r = 0; r < NB; r++) cfg_is_io[r] = cio[r];
    end

    bar_window_decoder #(.NUM_BARS(NB)) i_bar_window_decoder (
        .clk(clk), .rst(rst), .io_space_en(io_en), .mem_space_en(mem_en),
        .cfg_value(cfg_value), .cfg_size(cfg_size), .cfg_is_io(cfg_is_io),
        .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_is_io(txn_is_io),
        .win_valid(win_valid), .win_base(win_base),
        .hit(hit), .hit_region(hit_region)
    );

    // Reference model written from the requirements
    function automatic logic m_io(int r);
        return (r < NB) ? cio[r] : 1'b0;
    endfunction

    function automatic logic m_valid(int r);
        logic [31:0] b, l;
        logic io;
        io = m_io(r);
        b = cv[r] & ~(cs[r] - 32'd1);
        l = b + cs[r] - 32'd1;
        if (cs[r] == 0) return 1'b0;                     // R9
        if (io && !io_en) return 1'b0;                   // R2
        if (!io && !mem_en) return 1'b0;                 // R3
        if (r == NB && !cv[r][0]) return 1'b0;           // R4
        if (b == 0 || l <= b) return 1'b0;               // R6
        if (io && l >= 32'h0001_0000) return 1'b0;       // R7
        if (!io && l == 32'hFFFF_FFFF) return 1'b0;      // R8
        return 1'b1;
    endfunction

    function automatic logic [31:0] m_base(int r);
        return m_valid(r) ? (cv[r] & ~(cs[r] - 32'd1)) : 32'hFFFF_FFFF;  // R5
    endfunction

    task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
        failures++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic check_windows(string tag);
        @(posedge clk); #2;
        for (int r = 0; r < NR; r++) begin
            checks++;
            if (win_valid[r] !== m_valid(r) || win_base[r*32 +: 32] !== m_base(r))
                fail_line(tag, $sformatf("region %0d valid/base", r),
                          {31'd0, win_valid[r], win_base[r*32 +: 32]},
                          {31'd0, m_valid(r), m_base(r)});
        end
    endtask

    task automatic new_cfg(logic ioe, logic meme);
        @(negedge clk);
        txn_valid = 1'b0;
        io_en  = ioe;
        mem_en = meme;
    endtask

    // Driver: present one transaction and queue its expected result (R10)
    task automatic send_txn(logic v, logic [31:0] a, logic io, string tag);
        exp_t e;
        @(negedge clk);
        txn_valid = v; txn_addr = a; txn_is_io = io;
        e.hit = 1'b0; e.idx = '0; e.tag = tag;
        for (int r = NR - 1; r >= 0; r--)
            if (v && m_valid(r) && m_io(r) == io && a >= m_base(r) &&
                a <= m_base(r) + cs[r] - 32'd1) begin
                e.hit = 1'b1; e.idx = IDX_W'(r);
            end
        exp_q.push_back(e);
    endtask

    // Monitor: pop exactly one expectation per edge following a transaction
    initial begin
        forever begin
            @(posedge clk); #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (hit !== e.hit || hit_region !== e.idx)
                    fail_line(e.tag, "hit/region", {hit, hit_region}, {e.hit, e.idx});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin cv[r] = '0; cs[r] = '0; end
        for (int r = 0; r < NB; r++) cio[r] = 1'b0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (win_valid !== '0) fail_line("R1", "valid during reset", 64'(win_valid), 64'd0);
        checks++;
        if (win_base !== '1) fail_line("R1", "base during reset", 64'(win_base[31:0]), 64'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        checks++;
        if (hit !== 1'b0 || win_valid !== '0)
            fail_line("R1", "state after reset", {62'd0, hit, |win_valid}, 64'd0);

        // Config A: mixed regions, both spaces enabled (R5 R6 R7 R8 R9)
        new_cfg(1'b1, 1'b1);
        cv[0] = 32'h8000_1234; cs[0] = 32'h1000;  cio[0] = 1'b0;
        cv[1] = 32'h0000_C0F1; cs[1] = 32'h20;    cio[1] = 1'b1;
        cv[2] = 32'h0000_3000; cs[2] = 32'h0;     cio[2] = 1'b0;
        cv[3] = 32'h0000_0FFF; cs[3] = 32'h1000;  cio[3] = 1'b0;
        cv[4] = 32'h0001_0000; cs[4] = 32'h100;   cio[4] = 1'b1;
        cv[5] = 32'hFFFF_F000; cs[5] = 32'h1000;  cio[5] = 1'b0;
        cv[6] = 32'h000C_0001; cs[6] = 32'h1_0000;
        check_windows("R5/R6/R7/R8/R9");

        send_txn(1'b1, 32'h8000_1ABC, 1'b0, "R10 mem hit");
        send_txn(1'b1, 32'h8000_1000, 1'b0, "R10 low edge");
        send_txn(1'b1, 32'h8000_1FFF, 1'b0, "R10 high edge");
        send_txn(1'b1, 32'h8000_0FFF, 1'b0, "R10 below base");
        send_txn(1'b1, 32'h0000_C0FF, 1'b1, "R10 io hit");
        send_txn(1'b1, 32'h0000_C100, 1'b1, "R10 io past end");
        send_txn(1'b1, 32'h0000_C0E0, 1'b0, "R10 space mismatch");
        send_txn(1'b1, 32'h000C_8000, 1'b0, "R10 rom hit");
        send_txn(1'b0, 32'h8000_1000, 1'b0, "R12 idle");
        send_txn(1'b0, 32'h0000_C0E0, 1'b1, "R12 idle io");

        // Config B: I/O space disabled, size one window (R2, R6 wrap)
        new_cfg(1'b0, 1'b1);
        cv[2] = 32'h0000_0100; cs[2] = 32'h1; cio[2] = 1'b1;
        check_windows("R2/R6");
        send_txn(1'b1, 32'h0000_C0E4, 1'b1, "R2 io off");
        new_cfg(1'b1, 1'b1);
        check_windows("R6 size one");

        // Config C: memory space disabled (R3)
        new_cfg(1'b1, 1'b0);
        check_windows("R3");
        send_txn(1'b1, 32'h000C_0010, 1'b0, "R3 rom off");
        send_txn(1'b1, 32'h0000_C0E8, 1'b1, "R3 io still on");

        // Config D: ROM enable bit clear (R4)
        new_cfg(1'b1, 1'b1);
        cv[6] = 32'h000C_0000;
        check_windows("R4");
        send_txn(1'b1, 32'h000C_0010, 1'b0, "R4 rom bit clear");

        // Config E: overlapping memory windows (R11)
        new_cfg(1'b1, 1'b1);
        cv[0] = 32'h4000_0000; cs[0] = 32'h100;
        cv[3] = 32'h4000_0000; cs[3] = 32'h1000; cio[3] = 1'b0;
        cv[6] = 32'h4000_0001; cs[6] = 32'h1_0000;
        check_windows("R11 setup");
        send_txn(1'b1, 32'h4000_0010, 1'b0, "R11 lowest wins");
        send_txn(1'b1, 32'h4000_0800, 1'b0, "R11 middle wins");
        send_txn(1'b1, 32'h4000_8000, 1'b0, "R11 rom only");

        @(negedge clk);
        txn_valid = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        checks++;
        if (exp_q.size() != 0) fail_line("R10", "queue not drained", 64'(exp_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule